// File: doc/BRIEF.md
# Carry-Free Signed-Digit Adder

This block adds two W-digit signed-digit numbers and yields a (W+1)-digit signed-digit sum. It is meant to be the node of a partial product reduction tree. Every digit is -1, 0 or +1. It is carried as a pair of bits, one for the positive part and one for the negative part, and its value is positive minus negative. Digit i has weight 2^i.

No carry ripples across the word. Each position splits the sum of its two operand digits into an outgoing signed carry and an interim digit. The choice of interim digit is steered by a one-bit look-ahead flag from the position below. That flag says whether the lower operand digits are both non-negative, and so fixes the sign the incoming carry can take. An interim digit plus an incoming carry therefore always stays within {-1, 0, +1}, and each output digit depends only on a bounded window of operand digits. The logic depth is the same for any W. The sum is captured in one output register, so the result appears one clock after the operands are applied.

Top module: `rb_adder`

## Requirements
- R1: One clock after operands are sampled with reset inactive, the value of the sum, taken as the sum over i of (sumPos[i] - sumNeg[i]) * 2^i, equals the value of operand A plus the value of operand B.
- R2: An operand digit i is carried on bit i of its positive and negative vectors, with code (0,0)=0, (1,0)=+1, (0,1)=-1. Operands never present the (1,1) code.
- R3: Swapping operand A with operand B leaves every output digit unchanged.
- R4: No output digit ever shows the (1,1) code. Only (0,0), (1,0) and (0,1) appear.
- R5: Output digit j depends only on operand digits j, j-1 and j-2. Changing operand digits above position k leaves output digits 0..k unchanged.
- R6: While reset is asserted, all output digits are (0,0).
- R7: Adding an all-zero operand to an all-zero operand gives an all-(0,0) sum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| aPos | input | W | Positive bits of operand A digits |
| aNeg | input | W | Negative bits of operand A digits |
| bPos | input | W | Positive bits of operand B digits |
| bNeg | input | W | Negative bits of operand B digits |
| sumPos | output | W+1 | Positive bits of the registered sum digits |
| sumNeg | output | W+1 | Negative bits of the registered sum digits |

## Verification
The properties assume that no operand digit arrives with both bits set, and one property watches the inputs for exactly that. The locality property also assumes reset was already inactive on the previous edge. The stimulus builds every digit by picking one of the three legal codes. It never sets both bits of a pair. Where operands are spliced together, each digit is taken whole from one source, so the merged digit stays legal.

// File: rtl/rbadd_pkg.sv
package rbadd_pkg;

  typedef struct packed {
    logic pos;
    logic neg;
  } sdDigit_t;

  localparam sdDigit_t SD_ZERO = '{pos: 1'b0, neg: 1'b0};

  function automatic logic signed [2:0] sdValue(input sdDigit_t d);
    return $signed({2'b00, d.pos}) - $signed({2'b00, d.neg});
  endfunction

  function automatic sdDigit_t sdEncode(input logic signed [2:0] v);
    sdDigit_t d;
    d.pos = (v == 3'sd1);
    d.neg = (v == -3'sd1);
    return d;
  endfunction

endpackage

// File: rtl/rbadd_cell.sv
module rbadd_cell
  import rbadd_pkg::*;
(
  input  sdDigit_t aDigit,
  input  sdDigit_t bDigit,
  input  logic     lowNonNeg,
  output sdDigit_t carryOut,
  output sdDigit_t interim,
  output logic     nonNeg
);

  logic signed [2:0] pairSum;

  always_comb begin
    pairSum  = sdValue(aDigit) + sdValue(bDigit);
    carryOut = SD_ZERO;
    interim  = SD_ZERO;
    case (pairSum)
      3'sd2:  carryOut = sdEncode(3'sd1);
      -3'sd2: carryOut = sdEncode(-3'sd1);
      3'sd1: begin
        if (lowNonNeg) begin
          carryOut = sdEncode(3'sd1);
          interim  = sdEncode(-3'sd1);
        end else begin
          interim  = sdEncode(3'sd1);
        end
      end
      -3'sd1: begin
        if (lowNonNeg) begin
          interim  = sdEncode(-3'sd1);
        end else begin
          carryOut = sdEncode(-3'sd1);
          interim  = sdEncode(3'sd1);
        end
      end
      default: begin
        carryOut = SD_ZERO;
        interim  = SD_ZERO;
      end
    endcase
    nonNeg = !aDigit.neg && !bDigit.neg;
  end

endmodule

// File: rtl/rbadd_merge.sv
module rbadd_merge
  import rbadd_pkg::*;
(
  input  sdDigit_t interim,
  input  sdDigit_t carryIn,
  output sdDigit_t digit
);

  logic signed [2:0] total;

  always_comb begin
    total = sdValue(interim) + sdValue(carryIn);
    digit = sdEncode(total);
  end

endmodule

// File: rtl/rb_adder.sv
module rb_adder
  import rbadd_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] aPos,
  input  logic [W-1:0] aNeg,
  input  logic [W-1:0] bPos,
  input  logic [W-1:0] bNeg,
  output logic [W:0]   sumPos,
  output logic [W:0]   sumNeg
);

  localparam int OUT_DIGITS = W + 1;

  sdDigit_t         carryVec   [W];
  sdDigit_t         interimVec [W];
  logic     [W-1:0] nonNegVec;
  sdDigit_t         nextDigit  [OUT_DIGITS];

  for (genvar i = 0; i < W; i++) begin : g_pos
    sdDigit_t aD, bD, cIn;
    logic     lowFlag;

    assign aD = '{pos: aPos[i], neg: aNeg[i]};
    assign bD = '{pos: bPos[i], neg: bNeg[i]};

    if (i == 0) begin : g_lsb
      assign lowFlag = 1'b1;
      assign cIn     = SD_ZERO;
    end else begin : g_upper
      assign lowFlag = nonNegVec[i-1];
      assign cIn     = carryVec[i-1];
    end

    rbadd_cell u_cell (
      .aDigit    (aD),
      .bDigit    (bD),
      .lowNonNeg (lowFlag),
      .carryOut  (carryVec[i]),
      .interim   (interimVec[i]),
      .nonNeg    (nonNegVec[i])
    );

    rbadd_merge u_merge (
      .interim (interimVec[i]),
      .carryIn (cIn),
      .digit   (nextDigit[i])
    );
  end

  assign nextDigit[W] = carryVec[W-1];

  for (genvar j = 0; j < OUT_DIGITS; j++) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        sumPos[j] <= 1'b0;
        sumNeg[j] <= 1'b0;
      end else begin
        sumPos[j] <= nextDigit[j].pos;
        sumNeg[j] <= nextDigit[j].neg;
      end
    end
  end

endmodule

// File: rtl/rb_adder_check.sv
module rb_adder_check #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rstN,
  input logic [W-1:0] aPos,
  input logic [W-1:0] aNeg,
  input logic [W-1:0] bPos,
  input logic [W-1:0] bNeg,
  input logic [W:0]   sumPos,
  input logic [W:0]   sumNeg
);

  function automatic longint digitsVal(input logic [W:0] p, input logic [W:0] n);
    longint v = 0;
    for (int i = W; i >= 0; i--) begin
      v = v * 2 + longint'(p[i]) - longint'(n[i]);
    end
    return v;
  endfunction

  longint inVal;
  assign inVal = digitsVal({1'b0, aPos}, {1'b0, aNeg}) + digitsVal({1'b0, bPos}, {1'b0, bNeg});

  // R2: operand digits never carry the (1,1) code
  p_legal_input_r2: assert property (@(posedge clk) disable iff (!rstN)
    ((aPos & aNeg) == '0) && ((bPos & bNeg) == '0));

  // R1: registered sum value equals operand sum of previous edge
  p_sum_value_r1: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> digitsVal(sumPos, sumNeg) == $past(inVal));

  // R4: no output digit uses the (1,1) code
  p_no_both_r4: assert property (@(posedge clk) disable iff (!rstN)
    (sumPos & sumNeg) == '0);

  // R5: the two lowest output digits see only the two lowest operand digits
  p_local_low_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && aPos[1:0] == $past(aPos[1:0]) && aNeg[1:0] == $past(aNeg[1:0])
     && bPos[1:0] == $past(bPos[1:0]) && bNeg[1:0] == $past(bNeg[1:0]))
    |=> (sumPos[1:0] == $past(sumPos[1:0]) && sumNeg[1:0] == $past(sumNeg[1:0])));

  // R7: zero plus zero gives an all-zero digit vector
  p_zero_sum_r7: assert property (@(posedge clk) disable iff (!rstN)
    (aPos == '0 && aNeg == '0 && bPos == '0 && bNeg == '0)
    |=> (sumPos == '0 && sumNeg == '0));

endmodule

bind rb_adder rb_adder_check #(.W(W)) chk (.*);

// File: tb/rb_adder_test.sv
`timescale 1ns/1ps
module rb_adder_test;

  localparam int W  = 16;
  localparam int WS = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [W-1:0] aPos = '0, aNeg = '0, bPos = '0, bNeg = '0;
  logic [W:0]   sumPos, sumNeg;
  logic [WS:0]  sumPosS, sumNegS;

  int tests = 0;
  int fails = 0;
  longint qBig[$];
  longint qSmall[$];

  always #2.5 clk = ~clk;

  rb_adder #(.W(W)) uut (
    .clk(clk), .rstN(rstN), .aPos(aPos), .aNeg(aNeg), .bPos(bPos), .bNeg(bNeg),
    .sumPos(sumPos), .sumNeg(sumNeg)
  );

  rb_adder #(.W(WS)) uutSmall (
    .clk(clk), .rstN(rstN), .aPos(aPos[WS-1:0]), .aNeg(aNeg[WS-1:0]),
    .bPos(bPos[WS-1:0]), .bNeg(bNeg[WS-1:0]),
    .sumPos(sumPosS), .sumNeg(sumNegS)
  );

  function automatic longint val(input logic [W:0] p, input logic [W:0] n);
    longint v = 0;
    for (int i = W; i >= 0; i--) v = v * 2 + longint'(p[i]) - longint'(n[i]);
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic compare();
    longint e;
    if (qBig.size() > 0) begin
      e = qBig.pop_front();
      check(val(sumPos, sumNeg) == e, "R1 wide", val(sumPos, sumNeg), e);
      check((sumPos & sumNeg) == '0, "R4 wide", longint'(sumPos & sumNeg), 0);
    end
    if (qSmall.size() > 0) begin
      e = qSmall.pop_front();
      check(val({'0, sumPosS}, {'0, sumNegS}) == e, "R1 small",
            val({'0, sumPosS}, {'0, sumNegS}), e);
      check((sumPosS & sumNegS) == '0, "R4 small", longint'(sumPosS & sumNegS), 0);
    end
  endtask

  task automatic drive(input logic [W-1:0] ap, input logic [W-1:0] an,
                       input logic [W-1:0] bp, input logic [W-1:0] bn);
    logic [W-1:0] lowMask;
    lowMask = (W)'((1 << WS) - 1);
    @(negedge clk);
    compare();
    aPos = ap; aNeg = an; bPos = bp; bNeg = bn;
    qBig.push_back(val({1'b0, ap}, {1'b0, an}) + val({1'b0, bp}, {1'b0, bn}));
    qSmall.push_back(val({1'b0, ap & lowMask}, {1'b0, an & lowMask})
                   + val({1'b0, bp & lowMask}, {1'b0, bn & lowMask}));
  endtask

  task automatic randOp(output logic [W-1:0] p, output logic [W-1:0] n);
    p = '0; n = '0;
    for (int i = 0; i < W; i++) begin
      case ($urandom_range(0, 2))
        1: p[i] = 1'b1;
        2: n[i] = 1'b1;
        default: ;
      endcase
    end
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    tests++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] ap, an, bp, bn, ap2, an2, bp2, bn2, mask;
    logic [W:0] snapP, snapN, outMask;
    int k;

    // R6: outputs held at zero while reset is low, even with nonzero operands
    aPos = 16'h00F3; bNeg = 16'h0F00;
    repeat (3) @(negedge clk);
    check(sumPos == '0 && sumNeg == '0, "R6", longint'(sumPos | sumNeg), 0);
    check(sumPosS == '0 && sumNegS == '0, "R6 small", longint'(sumPosS | sumNegS), 0);
    rstN = 1'b1;

    // R7: zero plus zero
    drive('0, '0, '0, '0);
    drive('0, '0, '0, '0);
    @(negedge clk);
    compare();
    check(sumPos == '0 && sumNeg == '0, "R7", longint'(sumPos | sumNeg), 0);

    // R2: digit weights and codes: +1 at digit 5 plus -1 at digit 0 is 31
    drive(16'h0020, '0, '0, 16'h0001);
    drive(16'h0020, '0, '0, 16'h0001);
    @(negedge clk);
    compare();
    check(val(sumPos, sumNeg) == 31, "R2", val(sumPos, sumNeg), 31);

    // R1 boundaries: all +1, all -1, opposite extremes
    drive('1, '0, '1, '0);
    drive('0, '1, '0, '1);
    drive('1, '0, '0, '1);
    drive(16'hAAAA, 16'h5555, 16'h5555, 16'hAAAA);
    drive(16'hFFFF, 16'h0000, 16'h0001, 16'h0000);

    // R1/R4: random operands
    for (int t = 0; t < 300; t++) begin
      randOp(ap, an);
      randOp(bp, bn);
      drive(ap, an, bp, bn);
    end

    // R1/R4: exhaustive over the small instance (3^(2*WS) combinations)
    for (int code = 0; code < 729; code++) begin
      int c;
      c = code;
      ap = '0; an = '0; bp = '0; bn = '0;
      for (int d = 0; d < 2 * WS; d++) begin
        int sel;
        sel = c % 3;
        c = c / 3;
        if (d < WS) begin
          if (sel == 1) ap[d] = 1'b1;
          if (sel == 2) an[d] = 1'b1;
        end else begin
          if (sel == 1) bp[d-WS] = 1'b1;
          if (sel == 2) bn[d-WS] = 1'b1;
        end
      end
      drive(ap, an, bp, bn);
    end

    // R5: changing digits above k leaves output digits 0..k intact
    for (int t = 0; t < 50; t++) begin
      randOp(ap, an);
      randOp(bp, bn);
      drive(ap, an, bp, bn);
      drive(ap, an, bp, bn);
      @(negedge clk);
      compare();
      snapP = sumPos; snapN = sumNeg;
      k = $urandom_range(0, W - 2);
      mask = (W)'((64'd1 << (k + 1)) - 1);
      outMask = {1'b0, mask};
      randOp(ap2, an2);
      randOp(bp2, bn2);
      ap2 = (ap & mask) | (ap2 & ~mask);
      an2 = (an & mask) | (an2 & ~mask);
      bp2 = (bp & mask) | (bp2 & ~mask);
      bn2 = (bn & mask) | (bn2 & ~mask);
      drive(ap2, an2, bp2, bn2);
      drive(ap2, an2, bp2, bn2);
      @(negedge clk);
      compare();
      check(((sumPos & outMask) == (snapP & outMask)) && ((sumNeg & outMask) == (snapN & outMask)),
            "R5", longint'({sumPos & outMask, sumNeg & outMask}),
            longint'({snapP & outMask, snapN & outMask}));
    end

    // R3: operand order does not change any digit
    for (int t = 0; t < 20; t++) begin
      randOp(ap, an);
      randOp(bp, bn);
      drive(ap, an, bp, bn);
      drive(ap, an, bp, bn);
      @(negedge clk);
      compare();
      snapP = sumPos; snapN = sumNeg;
      drive(bp, bn, ap, an);
      drive(bp, bn, ap, an);
      @(negedge clk);
      compare();
      check(sumPos == snapP && sumNeg == snapN, "R3",
            longint'({sumPos, sumNeg}), longint'({snapP, snapN}));
    end

    @(negedge clk);
    compare();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule